// File: doc/BRIEF.md
# 3B/4B Line Codec with Frame Alignment

This block turns 3-bit data words into 4-bit line words and recovers them from a serial stream. Six data values map to balanced words with two ones and two zeros. The two remaining data values each have two forms of opposite disparity. The encoder holds a one-bit running disparity flag and uses it to pick the form, so the line stays balanced over time. On request, the transmit side sends a fixed four-word alignment sequence. While that sequence is in flight, it holds off new data through a ready signal.

The receive side takes one line bit per enabled cycle, most significant bit of each word first. It watches a 16-bit sliding window for the alignment sequence, which can match at only one bit offset. When the window matches, the receiver commits to that frame boundary. From then on it decodes every fourth enabled bit as a word. Each decoded word is classed as data, control (one of the four alignment words) or a violation. A violation is a word outside the code table, or an unbalanced data word whose form is not the one the disparity flag expects.

Top module: `line_code_3b4b`

## Requirements
- R1: Data values 0 through 5 encode, in order, to 0011, 0101, 0110, 1001, 1010 and 1100 (bit 3 first on the line).
- R2: Data 6 encodes to 0100 when the transmit disparity flag is 0 and to 1011 when it is 1. Data 7 encodes to 0010 or 1101 under the same rule. Each of these words inverts the flag. The flag is 0 after reset.
- R3: A sync request accepted while the sequencer is idle emits 0111, 1110, 1000 and 0001 on four consecutive cycles. The sequence leaves the disparity flag unchanged.
- R4: tx_ready is low whenever tx_sync is high or a sync sequence is in progress. Data presented while tx_ready is low is not encoded.
- R5: tx_word_valid is high for exactly one cycle, the cycle after each accepted data word or sequence step, and low otherwise.
- R6: The receiver shifts in rx_bit on each cycle with rx_en high. When the last 16 received bits equal 0111_1110_1000_0001, rx_align pulses and rx_locked goes high on the next cycle. No word is reported before lock.
- R7: Once locked, every fourth enabled bit after the boundary completes a word. rx_valid then pulses for one cycle with the decoded value on rx_data.
- R8: The line words 0111, 1110, 1000 and 0001 decode as control (rx_ctl high, rx_err low, rx_data 0).
- R9: The line words 0000 and 1111 decode with rx_err high, rx_ctl low and rx_data 0.
- R10: After alignment, the first unbalanced data word is accepted in either form. Each later one must be the form opposite to the previous unbalanced word, otherwise rx_err is high. The receiver's expectation always follows the form it actually received.
- R11: A sequence match while already locked restarts framing at the new boundary. No word is reported in the cycle of rx_align, even when the old framing would have completed a word there.
- R12: A cycle with rx_en low changes no receive state and produces neither rx_valid nor rx_align.
- R13: During reset, tx_word_valid, rx_locked, rx_valid and rx_align are low and tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Data word present |
| tx_data | input | 3 | Data word to encode |
| tx_sync | input | 1 | Request for the alignment sequence |
| tx_ready | output | 1 | Data word is taken this cycle if tx_valid |
| tx_word | output | 4 | Encoded line word, bit 3 sent first |
| tx_word_valid | output | 1 | tx_word holds a new word |
| rx_en | input | 1 | rx_bit carries a line bit this cycle |
| rx_bit | input | 1 | Serial line bit |
| rx_locked | output | 1 | Frame boundary found |
| rx_align | output | 1 | Alignment sequence matched this cycle |
| rx_valid | output | 1 | Decoded word present |
| rx_data | output | 3 | Decoded data value |
| rx_ctl | output | 1 | Word was an alignment (control) word |
| rx_err | output | 1 | Code or disparity violation |

## Verification
Two pairs of functions can fall in the same cycle. On the transmit side, a sync request can arrive together with a valid data word. The stimulus raises both together, repeatedly, and the reference model expects the sequence to start while the data word stays unconsumed. On the receive side, a fresh alignment match can land exactly where the old framing would complete a word. The bench provokes this by injecting the sequence after four filler bits, and again after two filler bits, which shifts the boundary. The model expects a bare rx_align pulse with no word and then framing from the new boundary, and it compares every output on every clock.

// File: rtl/line_code_3b4b.sv
module line_code_3b4b (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [2:0] tx_data,
  input  logic       tx_sync,
  output logic       tx_ready,
  output logic [3:0] tx_word,
  output logic       tx_word_valid,
  input  logic       rx_en,
  input  logic       rx_bit,
  output logic       rx_locked,
  output logic       rx_align,
  output logic       rx_valid,
  output logic [2:0] rx_data,
  output logic       rx_ctl,
  output logic       rx_err
);

  localparam logic [15:0] ALIGN_SEQ = 16'b0111_1110_1000_0001;

  typedef enum logic [2:0] {K_BAL, K_EVEN, K_ODD, K_CTL, K_BAD} kind_t;

  function automatic logic [3:0] encode(input logic [2:0] d, input logic odd);
    case (d)
      3'd0:    encode = 4'b0011;
      3'd1:    encode = 4'b0101;
      3'd2:    encode = 4'b0110;
      3'd3:    encode = 4'b1001;
      3'd4:    encode = 4'b1010;
      3'd5:    encode = 4'b1100;
      3'd6:    encode = odd ? 4'b1011 : 4'b0100;
      default: encode = odd ? 4'b1101 : 4'b0010;
    endcase
  endfunction

  function automatic logic [3:0] seq_word(input logic [1:0] step);
    case (step)
      2'd0:    seq_word = ALIGN_SEQ[15:12];
      2'd1:    seq_word = ALIGN_SEQ[11:8];
      2'd2:    seq_word = ALIGN_SEQ[7:4];
      default: seq_word = ALIGN_SEQ[3:0];
    endcase
  endfunction

  // transmit
  logic [1:0] seq_step;
  logic       tx_rd;
  logic       seq_run;

  assign tx_ready = (seq_step == 2'd0) && !tx_sync;
  assign seq_run  = tx_sync || (seq_step != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_step      <= 2'd0;
      tx_rd         <= 1'b0;
      tx_word       <= 4'd0;
      tx_word_valid <= 1'b0;
    end else begin
      tx_word_valid <= 1'b0;
      if (seq_run) begin
        tx_word       <= seq_word(seq_step);
        tx_word_valid <= 1'b1;
        seq_step      <= seq_step + 2'd1;
      end else if (tx_valid) begin
        tx_word       <= encode(tx_data, tx_rd);
        tx_word_valid <= 1'b1;
        if (tx_data[2:1] == 2'b11) tx_rd <= !tx_rd;
      end
    end
  end

  assert_seq_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sync && seq_step == 2'd0) |=> (tx_word_valid && tx_word == 4'b0111));
  assert_ready_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step != 2'd0) |-> !tx_ready);
  assert_take_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> tx_word_valid);
  assert_balanced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_data < 3'd6) |=> ($countones(tx_word) == 2));
  assert_flag_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_data[2:1] == 2'b11) |=> (tx_rd != $past(tx_rd)));

  // receive
  logic [14:0] rx_sh;
  logic [1:0]  rx_cnt;
  logic        rx_rd;
  logic        rx_rdk;
  logic [15:0] win;
  logic        hit;
  kind_t       kind;
  logic [2:0]  dec;

  assign win = {rx_sh, rx_bit};
  assign hit = (win == ALIGN_SEQ);

  always_comb begin
    dec  = 3'd0;
    kind = K_BAL;
    case (win[3:0])
      4'b0011: dec = 3'd0;
      4'b0101: dec = 3'd1;
      4'b0110: dec = 3'd2;
      4'b1001: dec = 3'd3;
      4'b1010: dec = 3'd4;
      4'b1100: dec = 3'd5;
      4'b0100: begin dec = 3'd6; kind = K_EVEN; end
      4'b1011: begin dec = 3'd6; kind = K_ODD;  end
      4'b0010: begin dec = 3'd7; kind = K_EVEN; end
      4'b1101: begin dec = 3'd7; kind = K_ODD;  end
      4'b0111, 4'b1110, 4'b1000, 4'b0001: kind = K_CTL;
      default: kind = K_BAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh     <= 15'd0;
      rx_cnt    <= 2'd0;
      rx_rd     <= 1'b0;
      rx_rdk    <= 1'b0;
      rx_locked <= 1'b0;
      rx_align  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= 3'd0;
      rx_ctl    <= 1'b0;
      rx_err    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_align <= 1'b0;
      if (rx_en) begin
        rx_sh <= win[14:0];
        if (hit) begin
          rx_locked <= 1'b1;
          rx_align  <= 1'b1;
          rx_cnt    <= 2'd0;
          rx_rdk    <= 1'b0;
        end else if (rx_locked) begin
          rx_cnt <= rx_cnt + 2'd1;
          if (rx_cnt == 2'd3) begin
            rx_valid <= 1'b1;
            rx_data  <= dec;
            rx_ctl   <= (kind == K_CTL);
            rx_err   <= (kind == K_BAD) ||
                        (rx_rdk && ((kind == K_EVEN && rx_rd) || (kind == K_ODD && !rx_rd)));
            if (kind == K_EVEN || kind == K_ODD) begin
              rx_rd  <= (kind == K_EVEN);
              rx_rdk <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_no_word_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_locked);
  assert_align_no_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_align |-> !rx_valid);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_valid && !rx_align));
  assert_ctl_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ctl) |-> !rx_err);

endmodule

// File: tb/sim_line_code_3b4b.sv
`timescale 1ns/1ps
module sim_line_code_3b4b;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_sync = 1'b0, rx_en = 1'b0, rx_bit = 1'b0;
  logic [2:0] tx_data = 3'd0;
  logic tx_ready, tx_word_valid, rx_locked, rx_align, rx_valid, rx_ctl, rx_err;
  logic [3:0] tx_word;
  logic [2:0] rx_data;

  always #2.5 clk = ~clk;

  line_code_3b4b u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sync(tx_sync),
    .tx_ready(tx_ready), .tx_word(tx_word), .tx_word_valid(tx_word_valid),
    .rx_en(rx_en), .rx_bit(rx_bit), .rx_locked(rx_locked), .rx_align(rx_align),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ctl(rx_ctl), .rx_err(rx_err));

  int n_chk = 0, n_fail = 0;
  bit loop_on = 1'b0;
  bit q[$];

  logic [3:0] ev[8] = '{4'h3, 4'h5, 4'h6, 4'h9, 4'hA, 4'hC, 4'h4, 4'h2};
  logic [3:0] od[8] = '{4'h3, 4'h5, 4'h6, 4'h9, 4'hA, 4'hC, 4'hB, 4'hD};
  logic [3:0] sy[4] = '{4'h7, 4'hE, 4'h8, 4'h1};

  // reference model state
  int m_sc = 0, m_rd = 0, m_cnt = 0;
  bit m_lock = 0, m_rdk = 0, m_exp_odd = 0;
  logic [15:0] hist = 16'd0;
  bit e_wv = 0, e_align = 0, e_rv = 0, e_ctl = 0, e_err = 0;
  logic [3:0] e_word = 4'd0;
  int e_data = 0;
  string ttag = "R5", rtag = "R12";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sc = 0; m_rd = 0; m_cnt = 0; m_lock = 0; m_rdk = 0; hist = 16'd0;
      e_wv = 0; e_align = 0; e_rv = 0;
    end else begin
      e_wv = 0; ttag = "R5";
      if (m_sc > 0 || tx_sync) begin
        e_word = sy[m_sc]; e_wv = 1; ttag = "R3"; m_sc = (m_sc + 1) % 4;
      end else if (tx_valid) begin
        e_wv = 1;
        if (tx_data < 6) begin e_word = ev[tx_data]; ttag = "R1"; end
        else begin
          e_word = m_rd ? od[tx_data] : ev[tx_data]; ttag = "R2"; m_rd = 1 - m_rd;
        end
      end
      e_align = 0; e_rv = 0; rtag = "R12";
      if (rx_en) begin
        hist = {hist[14:0], rx_bit};
        rtag = "R6";
        if (hist == 16'h7E81) begin
          rtag = m_lock ? "R11" : "R6";
          m_lock = 1; m_cnt = 0; m_rdk = 0; e_align = 1;
        end else if (m_lock) begin
          m_cnt++;
          if (m_cnt == 4) begin
            bit found, unb, isodd;
            m_cnt = 0; e_rv = 1; found = 0; unb = 0; isodd = 0; e_data = 0;
            e_ctl = 0; e_err = 0;
            for (int d = 0; d < 8; d++) begin
              if (ev[d] == hist[3:0]) begin found = 1; e_data = d; unb = (d >= 6); isodd = 0; end
              if (od[d] == hist[3:0] && d >= 6) begin found = 1; e_data = d; unb = 1; isodd = 1; end
            end
            for (int s = 0; s < 4; s++) if (sy[s] == hist[3:0]) e_ctl = 1;
            if (e_ctl) rtag = "R8";
            else if (!found) begin e_err = 1; rtag = "R9"; end
            else if (unb) begin
              rtag = m_rdk ? "R10" : "R7";
              if (m_rdk && isodd != m_exp_odd) e_err = 1;
              m_exp_odd = !isodd; m_rdk = 1;
            end else rtag = "R7";
          end
        end
      end
    end
  end

  // comparison on every clock
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      chk(tx_word_valid == 0, "R13", "tx_word_valid", tx_word_valid, 0);
      chk(rx_locked == 0, "R13", "rx_locked", rx_locked, 0);
      chk(rx_valid == 0 && rx_align == 0, "R13", "rx_valid|rx_align", rx_valid | rx_align, 0);
      chk(tx_ready == 1, "R13", "tx_ready", tx_ready, 1);
    end else begin
      chk(tx_word_valid == e_wv, "R5", "tx_word_valid", tx_word_valid, e_wv);
      if (e_wv) chk(tx_word == e_word, ttag, "tx_word", tx_word, e_word);
      chk(rx_locked == m_lock, "R6", "rx_locked", rx_locked, m_lock);
      chk(rx_align == e_align, rtag, "rx_align", rx_align, e_align);
      chk(rx_valid == e_rv, rtag, "rx_valid", rx_valid, e_rv);
      if (e_rv) begin
        chk(rx_data == 3'(e_data), rtag, "rx_data", rx_data, e_data);
        chk(rx_ctl == e_ctl, rtag, "rx_ctl", rx_ctl, e_ctl);
        chk(rx_err == e_err, rtag, "rx_err", rx_err, e_err);
      end
      #2;
      chk(tx_ready == (m_sc == 0 && !tx_sync), "R4", "tx_ready", tx_ready, (m_sc == 0 && !tx_sync));
    end
  end

  // loopback capture
  initial forever begin
    @(negedge clk);
    if (loop_on && tx_word_valid)
      for (int b = 3; b >= 0; b--) q.push_back(tx_word[b]);
  end

  // serial driver with random idle cycles
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && q.size() > 0 && ($urandom % 8) != 0) begin
      rx_en = 1'b1; rx_bit = q.pop_front();
    end else begin
      rx_en = 1'b0; rx_bit = 1'($urandom);
    end
  end

  task automatic push_word(input logic [3:0] w);
    for (int b = 3; b >= 0; b--) q.push_back(w[b]);
  endtask

  task automatic push_sync();
    for (int s = 0; s < 4; s++) push_word(sy[s]);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    q.push_back(1); q.push_back(0); q.push_back(1);
    loop_on = 1'b1;
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      #1;
      tx_sync  = (c == 0) || (c % 50 == 0) || (($urandom % 97) == 0);
      tx_valid = (c % 50 == 0) || (($urandom % 4) == 0);
      tx_data  = 3'($urandom);
    end
    @(negedge clk);
    #1 tx_sync = 1'b0; tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    loop_on = 1'b0;
    drain();
    // directed receive cases: forms, violations, control words
    push_sync();
    push_word(4'b0100); push_word(4'b0100); push_word(4'b1011); push_word(4'b0010);
    push_word(4'b1101); push_word(4'b0000); push_word(4'b1111);
    push_word(4'b0111); push_word(4'b1000); push_word(4'b0011);
    // realign landing on the old boundary
    push_word(4'b1010); push_sync(); push_word(4'b0101); push_word(4'b1101);
    // realign shifted by two bits
    q.push_back(1); q.push_back(1);
    push_sync();
    push_word(4'b0110); push_word(4'b1001); push_word(4'b1100); push_word(4'b0100); push_word(4'b0010);
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule